// File: doc/BRIEF.md
# Multiplexed-Address DRAM Write Sequencer

This block drives a DRAM with a multiplexed address bus so that the memory acts as a circular buffer in a digital delay line. It owns a 16-bit address counter. It presents the low byte of that counter as the row half and the high byte as the column half on a shared 8-bit bus. A ninth address line sits beside the bus. The three active-low strobes (row strobe, column strobe and write enable) follow a fixed nine-step pattern, so every memory cycle has the same length and the edge timing never varies.

Four memory cycles form one group. Together they cover all four combinations of the ninth row bit and the ninth column bit for one counter value. In two of these cycles the ninth line changes between the row strobe and the column strobe. The counter advances once per group, after the second cycle. The third and fourth cycles therefore already use the next address. An enable input can park the sequencer between cycles without losing or skipping an address. The step number and the cycle index are brought out for observation.

Top module: `dseq_top`

## Requirements
- R1: A synchronous reset (rst high) sets the counter to 0, the step to 0 and the cycle index to 0. While the reset is applied and just after it, all three strobes are high, the ninth line is 1 and the bus is 0.
- R2: The step output counts 0,1,...,8 and then returns to 0. Each return to 0 advances the cycle index 0,1,2,3,0.
- R3: The row strobe is low in steps 2 to 8, the column strobe in steps 5 to 8 and the write enable in steps 6 to 8. All three are high in steps 0 and 1.
- R4: The column strobe is never low unless the row strobe is low. The write enable is never low unless the column strobe is low.
- R5: The bus carries counter bits [7:0] in steps 1 to 3 and counter bits [15:8] in steps 4 to 8. In step 0 it keeps its previous value.
- R6: The ninth line carries the cycle's row bit in steps 0 to 2 and its column bit in steps 3 to 8. Row/column bits by cycle index are 1/1 for cycle 0, 0/1 for cycle 1, 0/0 for cycle 2 and 1/0 for cycle 3.
- R7: The counter rises by one, with carry from the low byte into the high byte, when step 8 of cycle 1 ends. Cycles 2 and 3 and the following cycle 0 and cycle 1 use the new value.
- R8: While en is low and the step is 0, the sequencer stays at step 0 with all strobes high and no output change. A cycle that has already left step 0 runs to step 8 regardless of en. When en returns, the next cycle continues with the cycle index and address where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Lets a new memory cycle start |
| addr_o | output | 8 | Multiplexed row/column address bus |
| a8_o | output | 1 | Ninth address line |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| dbg_step_o | output | 4 | Current step within the cycle (0 to 8) |
| dbg_cyc_o | output | 2 | Current cycle index within the group (0 to 3) |

## Verification
The counter increment and an enable stall can fall on the same clock edge. This happens when en is dropped during step 8 of cycle 1: the address must advance and the sequencer must then park at step 0 of cycle 2, with the bus still holding the old column byte. The bench forces exactly that edge and also toggles en at irregular points across many groups. A behavioural reference model is compared with the bus, the ninth line, all strobes and both debug outputs on every clock. A long uninterrupted run carries the low byte into the high byte. The bench confirms that the column half of the bus then reads 1.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    localparam int BYTE_W   = 8;
    localparam int N_STEPS  = 9;
    localparam int N_CYCLES = 4;

    // step numbers at which the pins change; the order is the cycle protocol
    localparam int S_ROW_BUS  = 1;
    localparam int S_RAS_FALL = 2;
    localparam int S_A8_COL   = 3;
    localparam int S_COL_BUS  = 4;
    localparam int S_CAS_FALL = 5;
    localparam int S_WE_FALL  = 6;

    // cycle index after which the address counter advances
    localparam int BUMP_CYCLE = 1;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic              a8;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
    } pins_t;

endpackage

// File: rtl/dseq_timing.sv
module dseq_timing #(
    parameter int STEPS  = dseq_pkg::N_STEPS,
    parameter int CYCLES = dseq_pkg::N_CYCLES,
    parameter int BUMP_AT = dseq_pkg::BUMP_CYCLE,
    localparam int SW = $clog2(STEPS),
    localparam int CW = $clog2(CYCLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [SW-1:0] step_q,
    output logic [CW-1:0] cyc_q,
    output logic [SW-1:0] step_d,
    output logic [CW-1:0] cyc_d,
    output logic          bump
);

    localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);
    localparam logic [CW-1:0] LAST_CYC  = CW'(CYCLES - 1);
    localparam logic [CW-1:0] BUMP_CYC  = CW'(BUMP_AT);

    typedef struct packed {
        logic [SW-1:0] step;
        logic [CW-1:0] cyc;
    } tstate_t;

    tstate_t cur_q, nxt_d;
    logic    bump_d;

    always_comb begin
        nxt_d  = cur_q;
        bump_d = 1'b0;
        if (cur_q.step == '0 && !en) begin
            nxt_d = cur_q;
        end else if (cur_q.step == LAST_STEP) begin
            nxt_d.step = '0;
            nxt_d.cyc  = (cur_q.cyc == LAST_CYC) ? '0 : cur_q.cyc + 1'b1;
            bump_d     = (cur_q.cyc == BUMP_CYC);
        end else begin
            nxt_d.step = cur_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign step_q = cur_q.step;
    assign cyc_q  = cur_q.cyc;
    assign step_d = nxt_d.step;
    assign cyc_d  = nxt_d.cyc;
    assign bump   = bump_d;

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST_STEP);                                          // R2

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step_q == '0 && !en) |=> (step_q == '0 && $stable(cyc_q)));   // R8

    AST_CYC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step_q == LAST_STEP) |=> (cyc_q != $past(cyc_q)));            // R2

endmodule

// File: rtl/dseq_addr_ctr.sv
module dseq_addr_ctr #(
    parameter int BYTE_W = dseq_pkg::BYTE_W,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    always_comb begin
        cnt_d = cnt_q;
        if (bump) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bump |=> $stable(cnt_q));                                     // R7

    AST_CNT_CARRY: assert property (@(posedge clk) disable iff (rst)
        (bump && cnt_q[BYTE_W-1:0] == '1) |=> (cnt_q[BYTE_W-1:0] == '0)); // R7

endmodule

// File: rtl/dseq_pattern.sv
module dseq_pattern #(
    parameter int BYTE_W = dseq_pkg::BYTE_W,
    parameter int SW     = 4,
    parameter int CW     = 2,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic [SW-1:0]    step,
    input  logic [CW-1:0]    cyc,
    input  logic [CNT_W-1:0] cnt,
    input  logic [BYTE_W-1:0] bus_prev,
    output dseq_pkg::pins_t  pins
);
    import dseq_pkg::*;

    logic row_bit, col_bit;

    // ninth-bit pairs per cycle index: 1/1, 0/1, 0/0, 1/0
    always_comb begin
        unique case (cyc)
            CW'(0):  begin row_bit = 1'b1; col_bit = 1'b1; end
            CW'(1):  begin row_bit = 1'b0; col_bit = 1'b1; end
            CW'(2):  begin row_bit = 1'b0; col_bit = 1'b0; end
            default: begin row_bit = 1'b1; col_bit = 1'b0; end
        endcase
    end

    always_comb begin
        pins.ras_n = !(step >= SW'(S_RAS_FALL));
        pins.cas_n = !(step >= SW'(S_CAS_FALL));
        pins.we_n  = !(step >= SW'(S_WE_FALL));
        pins.a8    = (step >= SW'(S_A8_COL)) ? col_bit : row_bit;
        if (step == '0) begin
            pins.addr = bus_prev;
        end else if (step < SW'(S_COL_BUS)) begin
            pins.addr = cnt[BYTE_W-1:0];
        end else begin
            pins.addr = cnt[CNT_W-1:BYTE_W];
        end
    end

endmodule

// File: rtl/dseq_top.sv
module dseq_top #(
    parameter int BYTE_W = dseq_pkg::BYTE_W,
    parameter int STEPS  = dseq_pkg::N_STEPS,
    parameter int CYCLES = dseq_pkg::N_CYCLES,
    localparam int SW    = $clog2(STEPS),
    localparam int CW    = $clog2(CYCLES),
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [BYTE_W-1:0] addr_o,
    output logic              a8_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [SW-1:0]     dbg_step_o,
    output logic [CW-1:0]     dbg_cyc_o
);
    import dseq_pkg::*;

    logic [SW-1:0]    step_q, step_d;
    logic [CW-1:0]    cyc_q, cyc_d;
    logic             bump;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    pins_t            pins_d, pins_q;

    dseq_timing #(
        .STEPS  (STEPS),
        .CYCLES (CYCLES),
        .BUMP_AT(BUMP_CYCLE)
    ) u_timing (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .step_q(step_q),
        .cyc_q (cyc_q),
        .step_d(step_d),
        .cyc_d (cyc_d),
        .bump  (bump)
    );

    dseq_addr_ctr #(
        .BYTE_W(BYTE_W)
    ) u_addr (
        .clk  (clk),
        .rst  (rst),
        .bump (bump),
        .cnt_q(cnt_q),
        .cnt_d(cnt_d)
    );

    // pins are decoded from the next state so that they switch on the clock edge
    dseq_pattern #(
        .BYTE_W(BYTE_W),
        .SW    (SW),
        .CW    (CW)
    ) u_pattern (
        .step    (step_d),
        .cyc     (cyc_d),
        .cnt     (cnt_d),
        .bus_prev(pins_q.addr),
        .pins    (pins_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q.addr  <= '0;
            pins_q.a8    <= 1'b1;
            pins_q.ras_n <= 1'b1;
            pins_q.cas_n <= 1'b1;
            pins_q.we_n  <= 1'b1;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign addr_o     = pins_q.addr;
    assign a8_o       = pins_q.a8;
    assign ras_n_o    = pins_q.ras_n;
    assign cas_n_o    = pins_q.cas_n;
    assign we_n_o     = pins_q.we_n;
    assign dbg_step_o = step_q;
    assign dbg_cyc_o  = cyc_q;

    AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst)
        !cas_n_o |-> !ras_n_o);                                        // R4

    AST_WE_NEEDS_CAS: assert property (@(posedge clk) disable iff (rst)
        !we_n_o |-> !cas_n_o);                                         // R4

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (dbg_step_o == '0) |-> (ras_n_o && cas_n_o && we_n_o));        // R3

    AST_ADDR_HELD_CAS: assert property (@(posedge clk) disable iff (rst)
        (!cas_n_o && $past(!cas_n_o)) |-> $stable(addr_o));            // R5

    AST_A8_HELD_STROBED: assert property (@(posedge clk) disable iff (rst)
        (!cas_n_o && $past(!cas_n_o)) |-> $stable(a8_o));              // R6

endmodule

// File: tb/dseq_top_bench.sv
`timescale 1ns/1ps
module dseq_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] addr_o;
    logic       a8_o, ras_n_o, cas_n_o, we_n_o;
    logic [3:0] dbg_step_o;
    logic [1:0] dbg_cyc_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    bit compare_on = 1'b0;
    bit saw_carry = 1'b0;

    always #2.5 clk = ~clk;

    dseq_top u_dseq_top (
        .clk(clk), .rst(rst), .en(en),
        .addr_o(addr_o), .a8_o(a8_o), .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o), .we_n_o(we_n_o),
        .dbg_step_o(dbg_step_o), .dbg_cyc_o(dbg_cyc_o)
    );

    // behavioural reference model
    int          m_step = 0;
    int          m_cyc  = 0;
    int unsigned m_cnt  = 0;
    logic [7:0]  e_bus  = 8'h00;
    logic        e_a8   = 1'b1;
    logic        e_ras  = 1'b1, e_cas = 1'b1, e_we = 1'b1;

    always @(posedge clk) begin
        if (rst) begin
            m_step = 0; m_cyc = 0; m_cnt = 0;
            e_bus = 8'h00; e_a8 = 1'b1; e_ras = 1'b1; e_cas = 1'b1; e_we = 1'b1;
        end else begin
            if (m_step == 0 && !en) begin
                // parked
            end else if (m_step == 8) begin
                if (m_cyc == 1) m_cnt = (m_cnt + 1) % 65536;
                m_step = 0;
                m_cyc = (m_cyc + 1) % 4;
            end else begin
                m_step = m_step + 1;
            end
            e_ras = !(m_step >= 2);
            e_cas = !(m_step >= 5);
            e_we  = !(m_step >= 6);
            if (m_step >= 3) e_a8 = (m_cyc == 0 || m_cyc == 1);
            else             e_a8 = (m_cyc == 0 || m_cyc == 3);
            if (m_step >= 4)      e_bus = 8'((m_cnt >> 8) & 255);
            else if (m_step >= 1) e_bus = 8'(m_cnt & 255);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2", "step", int'(dbg_step_o), m_step);
        check("R2", "cycle", int'(dbg_cyc_o), m_cyc);
        check("R3", "ras_n", int'(ras_n_o), int'(e_ras));
        check("R3", "cas_n", int'(cas_n_o), int'(e_cas));
        check("R3", "we_n", int'(we_n_o), int'(e_we));
        check("R4", "strobe order", int'((!cas_n_o && ras_n_o) || (!we_n_o && cas_n_o)), 0);
        check("R5", "bus", int'(addr_o), int'(e_bus));
        check("R6", "a8", int'(a8_o), int'(e_a8));
    endtask

    always @(negedge clk) begin
        if (compare_on && !finished) begin
            compare_all();
            if (dbg_step_o >= 4'd4 && addr_o == 8'h01) saw_carry = 1'b1;
        end
    end

    task automatic check_reset_state();
        check("R1", "step after reset", int'(dbg_step_o), 0);
        check("R1", "cycle after reset", int'(dbg_cyc_o), 0);
        check("R1", "bus after reset", int'(addr_o), 0);
        check("R1", "a8 after reset", int'(a8_o), 1);
        check("R1", "strobes after reset", int'({ras_n_o, cas_n_o, we_n_o}), 7);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();                       // R1 during reset
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();                       // R1 first idle cycle, en low
        compare_on = 1'b1;

        // R2 R3 R5 R6 R7: free running over several groups
        en = 1'b1;
        repeat (200) @(negedge clk);

        // R8: irregular enable pattern
        for (int k = 0; k < 400; k++) begin
            en = (k % 7 != 3) && (k % 11 != 5);
            @(negedge clk);
        end
        en = 1'b1;

        // R7 with R8: stall on the same edge as the counter increment
        while (!(dbg_step_o == 4'd8 && dbg_cyc_o == 2'd1)) @(negedge clk);
        en = 1'b0;
        repeat (6) @(negedge clk);
        check("R8", "parked step", int'(dbg_step_o), 0);
        check("R8", "parked cycle", int'(dbg_cyc_o), 2);
        en = 1'b1;

        // R7: long run until the low byte carries into the high byte
        repeat (9400) @(negedge clk);
        check("R7", "column byte after carry seen", int'(saw_carry), 1);

        // R1: reset in the middle of a cycle
        while (dbg_step_o != 4'd6) @(negedge clk);
        compare_on = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();
        en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();
        compare_on = 1'b1;
        en = 1'b1;
        repeat (80) @(negedge clk);

        finish_run();
    end

endmodule